// File: doc/BRIEF.md
# Dataflow thread frame scheduler

This block tracks non-blocking threads in a processor that keeps memory traffic apart from execution. A thread is created by taking a frame from a pool of free frames and setting a count of the inputs it still expects. Each arriving input lowers that count. When the count hits zero the thread is ready. It is first handed to the memory-side unit so that its registers can be loaded. It then waits in line for the execute unit and runs there without interruption. When it finishes, it goes back to the memory side to write its results out.

Threads leave the block as a tuple of frame index, instruction pointer and register-context number. The memory side has one port shared by load-phase work and store-phase work, and store-phase work always wins. A register context is taken when the load phase is accepted and is given back when the store phase is accepted. A frame returns to the pool only through an explicit release request, as when one branch of a conditional releases the thread of the branch that was not taken.

Top module: `thread_frame_sched`

## Requirements
- R1: After reset every frame is free and every context is unused. `alloc_ready` is 1 with `alloc_frame` 0, `arg_ready` is 1, and `mem_valid`, `ex_valid` and `arg_err` are 0.
- R2: An accepted create request (`alloc_valid` and `alloc_ready`) takes the lowest-numbered free frame, shown on `alloc_frame` in that cycle. It loads that frame's pending count from `alloc_count` and its instruction pointer from `alloc_ip`, and the thread starts out waiting.
- R3: An accepted input arrival lowers the named frame's count by one. An arrival at a frame whose count is already zero leaves the count as it is and raises `arg_err` for exactly the next cycle. A thread created with a count of zero stays waiting until it is released.
- R4: A waiting thread whose count reaches zero joins the load queue. The memory port offers load work with `mem_post` = 0, in the order the threads became ready.
- R5: When load work is accepted (`mem_valid` and `mem_ready`, `mem_post` = 0), the thread takes the lowest-numbered unused context and joins the execute queue. The execute port offers that queue in order.
- R6: Every entry offered on the memory or execute port carries the thread's frame index, its instruction pointer and its context number.
- R7: A fork request with a nonzero `fork_pred` that names a thread accepted by the execute port puts that thread into the store queue. A fork with a zero predicate, or one naming a thread that is not executing, has no effect.
- R8: Whenever the store queue holds a thread, the memory port offers store work (`mem_post` = 1) instead of load work, in store-queue order.
- R9: Load work is offered only while some context is unused. A thread keeps its context while executing. The context becomes unused when the thread's store work is accepted.
- R10: A release request returns the named frame to the pool only if that frame is waiting or has finished its store phase. In any other state the request is ignored.
- R11: While no frame is free, `alloc_ready` is 0 and a pending create request changes nothing.
- R12: `arg_ready` is 0 while the load queue is full, and arrivals are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Create request |
| alloc_count | input | CW | Number of inputs the new thread expects |
| alloc_ip | input | IW | Instruction pointer of the new thread |
| alloc_ready | output | 1 | A free frame exists |
| alloc_frame | output | FW | Frame granted to the create request |
| arg_valid | input | 1 | Input arrival |
| arg_frame | input | FW | Frame receiving the input |
| arg_ready | output | 1 | Arrival can be accepted |
| arg_err | output | 1 | Previous cycle's arrival found a zero count |
| fork_valid | input | 1 | Fork-to-store request |
| fork_frame | input | FW | Thread named by the fork |
| fork_pred | input | PW | Predicate value; zero cancels the fork |
| free_valid | input | 1 | Release request |
| free_frame | input | FW | Frame to release |
| mem_valid | output | 1 | Memory-side work offered |
| mem_ready | input | 1 | Memory side accepts the work |
| mem_post | output | 1 | 1 = store phase, 0 = load phase |
| mem_frame | output | FW | Frame of the offered work |
| mem_ip | output | IW | Instruction pointer of the offered work |
| mem_ctx | output | XW | Context of the offered work |
| ex_valid | output | 1 | Thread offered to the execute unit |
| ex_ready | input | 1 | Execute unit accepts the thread |
| ex_frame | output | FW | Frame of the offered thread |
| ex_ip | output | IW | Instruction pointer of the offered thread |
| ex_ctx | output | XW | Context of the offered thread |

## Verification
The case of interest is a cycle in which a thread becomes ready for its load phase while a fork sends another thread to the store queue, so that both kinds of memory-side work are pending together. The bench sets this up by sending a waiting thread's last input in the same cycle as a fork with a nonzero predicate on an executing thread. It expects the memory port to drain both store entries first, in order. Only then should the load entry appear, carrying the lowest context the stores released.

// File: rtl/thread_frame_sched.sv
module thread_frame_sched #(
  parameter int NFRAMES = 16,
  parameter int NCTX    = 4,
  parameter int QDEPTH  = 4,
  parameter int CW      = 4,
  parameter int IW      = 12,
  parameter int PW      = 8,
  localparam int FW  = $clog2(NFRAMES),
  localparam int XW  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int QW  = $clog2(QDEPTH),
  localparam int QCW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [CW-1:0] alloc_count,
  input  logic [IW-1:0] alloc_ip,
  output logic          alloc_ready,
  output logic [FW-1:0] alloc_frame,
  input  logic          arg_valid,
  input  logic [FW-1:0] arg_frame,
  output logic          arg_ready,
  output logic          arg_err,
  input  logic          fork_valid,
  input  logic [FW-1:0] fork_frame,
  input  logic [PW-1:0] fork_pred,
  input  logic          free_valid,
  input  logic [FW-1:0] free_frame,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_post,
  output logic [FW-1:0] mem_frame,
  output logic [IW-1:0] mem_ip,
  output logic [XW-1:0] mem_ctx,
  output logic          ex_valid,
  input  logic          ex_ready,
  output logic [FW-1:0] ex_frame,
  output logic [IW-1:0] ex_ip,
  output logic [XW-1:0] ex_ctx
);

  typedef enum logic [2:0] {S_FREE, S_WAIT, S_RDY, S_ENQ, S_EXEC, S_POSTQ, S_DONE} fstate_t;

  fstate_t       st   [NFRAMES];
  logic [CW-1:0] cnt  [NFRAMES];
  logic [IW-1:0] ipm  [NFRAMES];
  logic [XW-1:0] cx   [NFRAMES];
  logic [NCTX-1:0] ctx_busy;

  // queue 0: load, 1: execute, 2: store
  logic [FW-1:0]  qm [3][QDEPTH];
  logic [QW-1:0]  qh [3];
  logic [QW-1:0]  qt [3];
  logic [QCW-1:0] qc [3];
  logic [FW-1:0]  pdat [3];
  logic [2:0]     push, pop;

  logic          any_free, ctx_avail;
  logic [XW-1:0] ctx_pick;
  logic [FW-1:0] pre_hd, en_hd, post_hd;
  logic          al_hs, ar_hs, mem_hs, pre_hs, pst_hs, ex_hs;
  logic          free_ok, fork_ok, arr_fire;

  function automatic logic [QW-1:0] nxt(input logic [QW-1:0] p);
    return (p == QW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    any_free = 1'b0;
    alloc_frame = '0;
    for (int i = NFRAMES - 1; i >= 0; i--)
      if (st[i] == S_FREE) begin
        any_free = 1'b1;
        alloc_frame = FW'(i);
      end
    ctx_avail = 1'b0;
    ctx_pick = '0;
    for (int k = NCTX - 1; k >= 0; k--)
      if (!ctx_busy[k]) begin
        ctx_avail = 1'b1;
        ctx_pick = XW'(k);
      end
  end

  assign pre_hd  = qm[0][qh[0]];
  assign en_hd   = qm[1][qh[1]];
  assign post_hd = qm[2][qh[2]];

  assign alloc_ready = any_free;
  assign arg_ready   = qc[0] != QCW'(QDEPTH);

  assign mem_post  = qc[2] != '0;
  assign mem_valid = mem_post || (qc[0] != '0 && ctx_avail);
  assign mem_frame = mem_post ? post_hd : pre_hd;
  assign mem_ip    = ipm[mem_frame];
  assign mem_ctx   = mem_post ? cx[post_hd] : ctx_pick;

  assign ex_valid = qc[1] != '0;
  assign ex_frame = en_hd;
  assign ex_ip    = ipm[en_hd];
  assign ex_ctx   = cx[en_hd];

  assign al_hs  = alloc_valid && any_free;
  assign ar_hs  = arg_valid && arg_ready;
  assign mem_hs = mem_valid && mem_ready;
  assign pre_hs = mem_hs && !mem_post;
  assign pst_hs = mem_hs && mem_post;
  assign ex_hs  = ex_valid && ex_ready;

  assign free_ok  = free_valid && (st[free_frame] == S_WAIT || st[free_frame] == S_DONE);
  assign fork_ok  = fork_valid && fork_pred != '0 && st[fork_frame] == S_EXEC;
  assign arr_fire = ar_hs && cnt[arg_frame] == CW'(1) && st[arg_frame] == S_WAIT
                    && !(free_ok && free_frame == arg_frame);

  assign push = {fork_ok, pre_hs, arr_fire};
  assign pop  = {pst_hs, ex_hs, pre_hs};
  assign pdat[0] = arg_frame;
  assign pdat[1] = pre_hd;
  assign pdat[2] = fork_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFRAMES; i++) begin
        st[i]  <= S_FREE;
        cnt[i] <= '0;
        ipm[i] <= '0;
        cx[i]  <= '0;
      end
      for (int q = 0; q < 3; q++) begin
        qh[q] <= '0;
        qt[q] <= '0;
        qc[q] <= '0;
        for (int j = 0; j < QDEPTH; j++) qm[q][j] <= '0;
      end
      ctx_busy <= '0;
      arg_err  <= 1'b0;
    end else begin
      arg_err <= ar_hs && cnt[arg_frame] == '0;
      if (al_hs) begin
        st[alloc_frame]  <= S_WAIT;
        cnt[alloc_frame] <= alloc_count;
        ipm[alloc_frame] <= alloc_ip;
      end
      if (ar_hs && cnt[arg_frame] != '0) cnt[arg_frame] <= cnt[arg_frame] - 1'b1;
      if (arr_fire) st[arg_frame] <= S_RDY;
      if (pre_hs) begin
        st[pre_hd] <= S_ENQ;
        cx[pre_hd] <= ctx_pick;
        ctx_busy[ctx_pick] <= 1'b1;
      end
      if (ex_hs) st[en_hd] <= S_EXEC;
      if (fork_ok) st[fork_frame] <= S_POSTQ;
      if (pst_hs) begin
        st[post_hd] <= S_DONE;
        ctx_busy[cx[post_hd]] <= 1'b0;
      end
      if (free_ok) begin
        st[free_frame]  <= S_FREE;
        cnt[free_frame] <= '0;
      end
      for (int q = 0; q < 3; q++) begin
        if (push[q]) begin
          qm[q][qt[q]] <= pdat[q];
          qt[q] <= nxt(qt[q]);
        end
        if (pop[q]) qh[q] <= nxt(qh[q]);
        qc[q] <= qc[q] + QCW'(push[q]) - QCW'(pop[q]);
      end
    end
  end

  a_r2_alloc_waits: assert property (@(posedge clk) disable iff (!rst_n)
    al_hs |=> st[$past(alloc_frame)] == S_WAIT);

  a_r3_err_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (arg_err && !$past(al_hs && alloc_frame == arg_frame)) |-> cnt[$past(arg_frame)] == '0);

  a_r5_ex_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> st[ex_frame] == S_ENQ);

  a_r8_store_first: assert property (@(posedge clk) disable iff (!rst_n)
    (qc[2] != '0) |-> (mem_valid && mem_post));

  a_r9_ctx_held: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> ctx_busy[ex_ctx]);

  a_r9_no_queue_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push[1] || push[2]) |-> (qc[1] != QCW'(QDEPTH) || !push[1]) && (qc[2] != QCW'(QDEPTH) || !push[2]));

endmodule

// File: tb/sim_thread_frame_sched.sv
module sim_thread_frame_sched;
  localparam int FW = 4, IW = 12, CW = 4, XW = 2, PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, arg_valid = 0, fork_valid = 0, free_valid = 0, mem_ready = 0, ex_ready = 0;
  logic [CW-1:0] alloc_count = '0;
  logic [IW-1:0] alloc_ip = '0;
  logic [FW-1:0] arg_frame = '0, fork_frame = '0, free_frame = '0;
  logic [PW-1:0] fork_pred = '0;
  logic alloc_ready, arg_ready, arg_err, mem_valid, mem_post, ex_valid;
  logic [FW-1:0] alloc_frame, mem_frame, ex_frame;
  logic [IW-1:0] mem_ip, ex_ip;
  logic [XW-1:0] mem_ctx, ex_ctx;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  thread_frame_sched u0 (
    .clk, .rst_n,
    .alloc_valid, .alloc_count, .alloc_ip, .alloc_ready, .alloc_frame,
    .arg_valid, .arg_frame, .arg_ready, .arg_err,
    .fork_valid, .fork_frame, .fork_pred,
    .free_valid, .free_frame,
    .mem_valid, .mem_ready, .mem_post, .mem_frame, .mem_ip, .mem_ctx,
    .ex_valid, .ex_ready, .ex_frame, .ex_ip, .ex_ctx
  );

  // {count, ip, expected frame}
  localparam logic [19:0] VEC [4] = '{
    {4'd2, 12'h100, 4'd0}, {4'd1, 12'h110, 4'd1},
    {4'd3, 12'h120, 4'd2}, {4'd0, 12'h130, 4'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    alloc_valid = 0; arg_valid = 0; fork_valid = 0; free_valid = 0; mem_ready = 0; ex_ready = 0;
    #1;
  endtask

  task automatic do_alloc(input logic [CW-1:0] c, input logic [IW-1:0] ip, input int f);
    alloc_valid = 1; alloc_count = c; alloc_ip = ip; #1;
    chk("R2 alloc_ready", alloc_ready, 1);
    chk("R2 alloc_frame", alloc_frame, f);
    cyc();
  endtask

  task automatic arrive(input int f);
    arg_valid = 1; arg_frame = FW'(f); cyc();
  endtask

  task automatic memhs(input string tag, input int post, input int f, input int ctx);
    chk({tag, " mem_valid"}, mem_valid, 1);
    chk({tag, " mem_post"}, mem_post, post);
    chk({tag, " mem_frame"}, mem_frame, f);
    chk({tag, " mem_ctx"}, mem_ctx, ctx);
    mem_ready = 1; cyc();
  endtask

  task automatic exhs(input string tag, input int f, input int ctx, input int ip);
    chk({tag, " ex_valid"}, ex_valid, 1);
    chk({tag, " ex_frame"}, ex_frame, f);
    chk({tag, " ex_ctx"}, ex_ctx, ctx);
    chk({tag, " ex_ip"}, ex_ip, ip);
    ex_ready = 1; cyc();
  endtask

  task automatic do_fork(input int f, input int p);
    fork_valid = 1; fork_frame = FW'(f); fork_pred = PW'(p); cyc();
  endtask

  task automatic do_free(input int f);
    free_valid = 1; free_frame = FW'(f); cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_frame", alloc_frame, 0);
    chk("R1 arg_ready", arg_ready, 1);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 arg_err", arg_err, 0);

    for (int i = 0; i < 4; i++) do_alloc(VEC[i][19:16], VEC[i][15:4], int'(VEC[i][3:0]));

    arrive(1);
    chk("R4 mem_valid", mem_valid, 1);
    chk("R4 mem_post", mem_post, 0);
    chk("R6 mem_ip", mem_ip, 12'h110);
    arrive(0);
    chk("R3 count above zero", mem_frame, 1);
    arrive(0);
    chk("R4 fifo order", mem_frame, 1);
    arrive(3);
    chk("R3 err on zero count", arg_err, 1);
    arrive(0);
    chk("R3 err on drained count", arg_err, 1);
    cyc();
    chk("R3 err one cycle", arg_err, 0);

    memhs("R5", 0, 1, 0);
    memhs("R5", 0, 0, 1);
    exhs("R6", 1, 0, 12'h110);
    exhs("R5", 0, 1, 12'h100);
    chk("R5 ex drained", ex_valid, 0);
    chk("R3 zero-count thread waits", mem_valid, 0);

    do_fork(1, 0);
    chk("R7 zero predicate", mem_valid, 0);
    do_fork(3, 1);
    chk("R7 not executing", mem_valid, 0);
    do_fork(1, 5);
    arrive(2); arrive(2);
    arg_valid = 1; arg_frame = 2; fork_valid = 1; fork_frame = 0; fork_pred = 1; cyc();
    memhs("R8", 1, 1, 0);
    memhs("R8", 1, 0, 1);
    memhs("R9", 0, 2, 0);

    for (int i = 0; i < 4; i++) do_alloc(1, IW'(12'h140 + 16 * i), 4 + i);
    arrive(4); arrive(5); arrive(6);
    memhs("R5", 0, 4, 1);
    memhs("R5", 0, 5, 2);
    memhs("R5", 0, 6, 3);
    arrive(7);
    chk("R9 no context", mem_valid, 0);
    exhs("R9", 2, 0, 12'h120);
    do_fork(2, 1);
    memhs("R9", 1, 2, 0);
    memhs("R9", 0, 7, 0);

    chk("R10 next free", alloc_frame, 8);
    do_free(4);
    chk("R10 ignored", alloc_frame, 8);
    do_free(1);
    chk("R10 released", alloc_frame, 1);

    do_alloc(1, 12'h200, 1);
    for (int i = 8; i < 16; i++) do_alloc(1, IW'(12'h300 + i), i);
    chk("R11 stall", alloc_ready, 0);
    alloc_valid = 1; cyc();
    chk("R11 stall held", alloc_ready, 0);

    arrive(8); arrive(9); arrive(10); arrive(11);
    chk("R12 queue full", arg_ready, 0);
    chk("R9 all contexts held", mem_valid, 0);

    do_free(3);
    chk("R10 waiting released", alloc_ready, 1);
    chk("R11 resume", alloc_frame, 3);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule